// File: doc/BRIEF.md
# I2S to right-justified audio stream converter

This block takes a three-wire I2S audio stream (bit clock, word select and serial data) and re-emits it in the right-justified layout that some DACs need. Inside each channel slot, I2S puts the MSB-first sample near the front. The converter moves every data bit by a fixed number of bit clocks so that the sample ends exactly where the slot ends. It also flips the polarity of word select so that the receiver sees the channel marking it expects. The stream carries only sample bits, so no framing has to be decoded and no bits are added or dropped.

The whole block runs on the incoming bit clock. Data and word select are captured on its rising edge and pass through registers only. The outgoing bit clock is the incoming one, optionally complemented by a control input for receivers that capture on the opposite edge. The slot and sample widths are parameters. The bit delay is derived from them: slot width minus sample width minus one, which is 15 for 16-bit samples in 32-bit slots.

Top module: `i2s_rj_conv`

## Requirements
- R1: After each rising edge of `bclk_i` with reset low, `ws_o` equals the complement of the `ws_i` value sampled on that edge. A low `ws_i` (first channel) therefore appears as a high `ws_o`.
- R2: After rising edge k, `sd_o` equals the `sd_i` value sampled on rising edge k-15 (default parameters). This holds whatever `ws_i` does.
- R3: With 32-bit slots, a 16-bit sample is sent MSB first, starting one bit clock after the `ws_i` change. At the output it occupies slot bits 16 to 31 (counting from 0 at the `ws_o` change), with its LSB on the last bit before the next `ws_o` change. It stays in the slot of its own channel.
- R4: A synchronous active-high `rst` sampled on a rising edge clears the delay chain and `ws_o` to 0. `sd_o` then stays 0 for the first 15 rising edges after reset is released.
- R5: When `invert_bclk` is 0, `bclk_o` follows `bclk_i`. When it is 1, `bclk_o` is the complement of `bclk_i`. This path has no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Incoming bit clock; the block's only clock |
| rst | input | 1 | Synchronous active-high reset |
| invert_bclk | input | 1 | 1 complements the outgoing bit clock |
| ws_i | input | 1 | I2S word select (0 = first channel) |
| sd_i | input | 1 | I2S serial data, MSB first |
| bclk_o | output | 1 | Outgoing bit clock |
| ws_o | output | 1 | Registered, inverted word select |
| sd_o | output | 1 | Serial data delayed to right-justified alignment |

## Verification
The bench builds the block with its default 32-bit slots and 16-bit samples. This gives a 15-bit delay and a 16-register data chain. It can therefore follow every single output bit against its own history of driven inputs, and it can also rebuild complete output slots. Rebuilding slots brings within reach the sample placement in the last 16 bits of each slot, with MSB-only and LSB-only patterns, under the inverted word select. It also covers the 15-edge zero fill after reset. Random data with irregular word-select toggling and a toggling clock-inversion control round this out.

// File: rtl/i2s_rj_pkg.sv
package i2s_rj_pkg;
  localparam int unsigned SLOT_W_DEF   = 32;
  localparam int unsigned SAMPLE_W_DEF = 16;

  // Bit clocks needed to move an I2S sample (MSB one bit after the
  // word-select change) to the tail of its slot.
  function automatic int unsigned rj_shift(input int unsigned slot_w,
                                           input int unsigned sample_w);
    return slot_w - sample_w - 1;
  endfunction
endpackage

// File: rtl/i2s_rj_shift_line.sv
module i2s_rj_shift_line #(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] stg;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= 1'b0;
        else     stg[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= 1'b0;
        else     stg[i] <= stg[i-1];
      end
      // R2: every stage takes its predecessor's previous value
      a_r2_stage_advance: assert property (@(posedge clk) disable iff (rst)
        !rst |=> stg[i] == $past(stg[i-1]));
    end
  end

  assign dout = stg[DEPTH-1];

  // R4: a reset edge leaves the whole chain cleared
  a_r4_chain_cleared: assert property (@(posedge clk)
    rst |=> stg == '0);
endmodule

// File: rtl/i2s_rj_ws_stage.sv
module i2s_rj_ws_stage (
  input  logic clk,
  input  logic rst,
  input  logic ws_in,
  output logic ws_out
);
  always_ff @(posedge clk) begin
    if (rst) ws_out <= 1'b0;
    else     ws_out <= ~ws_in;
  end

  // R1: output word select is the complement of the last sampled input
  a_r1_ws_inverse: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ws_out == !$past(ws_in));
  // R4: reset clears the word-select register
  a_r4_ws_cleared: assert property (@(posedge clk)
    rst |=> !ws_out);
endmodule

// File: rtl/i2s_rj_bclk_out.sv
module i2s_rj_bclk_out (
  input  logic bclk_in,
  input  logic invert,
  output logic bclk_out
);
  assign bclk_out = bclk_in ^ invert;
endmodule

// File: rtl/i2s_rj_conv.sv
module i2s_rj_conv
  import i2s_rj_pkg::*;
#(
  parameter int unsigned SLOT_W   = SLOT_W_DEF,
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF
) (
  input  logic bclk_i,
  input  logic rst,
  input  logic invert_bclk,
  input  logic ws_i,
  input  logic sd_i,
  output logic bclk_o,
  output logic ws_o,
  output logic sd_o
);
  // Shift distance plus the capture register that word select also uses.
  localparam int unsigned SHIFT = rj_shift(SLOT_W, SAMPLE_W);
  localparam int unsigned DEPTH = SHIFT + 1;

  i2s_rj_shift_line #(.DEPTH(DEPTH)) u_data (
    .clk  (bclk_i),
    .rst  (rst),
    .din  (sd_i),
    .dout (sd_o)
  );

  i2s_rj_ws_stage u_ws (
    .clk    (bclk_i),
    .rst    (rst),
    .ws_in  (ws_i),
    .ws_out (ws_o)
  );

  i2s_rj_bclk_out u_bclk (
    .bclk_in  (bclk_i),
    .invert   (invert_bclk),
    .bclk_out (bclk_o)
  );
endmodule

// File: tb/i2s_rj_conv_tb_top.sv
module i2s_rj_conv_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inv = 1'b0;
  logic ws  = 1'b1;
  logic sd  = 1'b0;
  wire  bclk_o, ws_o, sd_o;

  always #5 clk = ~clk;

  i2s_rj_conv dut_i (
    .bclk_i(clk), .rst(rst), .invert_bclk(inv),
    .ws_i(ws), .sd_i(sd), .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o)
  );

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  logic hist_sd [0:8191];
  logic hist_ws [0:8191];
  logic [15:0] exp_slot [0:255];
  int slots = 0;
  int trans = 0;
  bit track = 0;
  logic [31:0] cap = '0;
  logic prev_wso = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Check the state after n edges, then drive the values for edge n+1.
  task automatic step(input logic d, input logic w);
    logic exp_d;
    @(negedge clk);
    exp_d = (n >= 16) ? hist_sd[n-15] : 1'b0;
    chk(sd_o === exp_d, "R2/R4 data delay", int'(sd_o), int'(exp_d));
    chk(ws_o === ~hist_ws[n], "R1 ws inverse", int'(ws_o), int'(~hist_ws[n]));
    chk(bclk_o === inv, "R5 bclk low phase", int'(bclk_o), int'(inv));
    if (track) begin
      if (ws_o !== prev_wso) begin
        trans++;
        if (trans >= 2 && trans - 2 < slots)
          chk(cap[15:0] === exp_slot[trans-2], "R3 right-justified slot",
              int'(cap[15:0]), int'(exp_slot[trans-2]));
        cap = {31'b0, sd_o};
      end else begin
        cap = {cap[30:0], sd_o};
      end
    end
    prev_wso = ws_o;
    sd = d;
    ws = w;
    hist_sd[n+1] = d;
    hist_ws[n+1] = w;
    n++;
  endtask

  task automatic send_frame(input logic [15:0] l, input logic [15:0] r);
    for (int ch = 0; ch < 2; ch++) begin
      logic [15:0] s;
      s = (ch == 0) ? l : r;
      exp_slot[slots] = s;
      slots++;
      for (int b = 0; b < 32; b++) begin
        logic d;
        d = (b >= 1 && b <= 16) ? s[16-b] : logic'($urandom % 2);
        step(d, logic'(ch));
      end
    end
  endtask

  task automatic mid_high_check();
    @(posedge clk);
    #2;
    chk(bclk_o === ~inv, "R5 bclk high phase", int'(bclk_o), int'(~inv));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    hist_sd[0] = 1'b0;
    hist_ws[0] = 1'b1;
    repeat (4) @(negedge clk);
    // R4: reset state
    chk(sd_o === 1'b0, "R4 reset data", int'(sd_o), 0);
    chk(ws_o === 1'b0, "R4 reset ws", int'(ws_o), 0);
    rst = 1'b0;
    sd = 1'b1; ws = 1'b1;
    hist_sd[1] = 1'b1; hist_ws[1] = 1'b1;
    n = 1;
    // R4: all-ones input must still read 0 for 15 edges
    for (int i = 0; i < 40; i++) step(1'b1, logic'((i / 32) % 2 == 0));
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1);
    track = 1;
    // R3: directed corner samples, then random ones
    send_frame(16'h8000, 16'h0001);
    send_frame(16'hFFFF, 16'h0000);
    send_frame(16'hA5A5, 16'h5A5A);
    send_frame(16'h0001, 16'h8000);
    for (int f = 0; f < 12; f++)
      send_frame(16'($urandom), 16'($urandom));
    for (int b = 0; b < 32; b++) step(1'b0, 1'b0);
    track = 0;
    // R2, R1, R5: random data with irregular ws and clock inversion
    for (int i = 0; i < 600; i++) begin
      if (i % 50 == 0) inv = ~inv;
      step(logic'($urandom % 2), logic'($urandom % 5 == 0 ? ~ws : ws));
    end
    for (int i = 0; i < 4; i++) begin
      inv = logic'(i % 2);
      mid_high_check();
    end
    finish_run();
  end
endmodule